// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block is the counting part of one channel of a legacy-style DMA controller. It holds a 16-bit base count and a 16-bit current count. It also holds an 8-bit page value that forms address bits 23:16 of the channel's transfers. The host reaches all three through an 8-bit register port. A shared byte pointer decides whether a count access reaches the low byte or the high byte.

The channel datapath reports each finished transfer with a one-cycle strobe, and each strobe lowers the current count by one. A programmed value N therefore gives N+1 transfers. Terminal count is flagged when the count wraps from zero to all ones.

With auto-initialize on, the current count is reloaded from the base, so the same block runs again. With auto-initialize off, a sticky done state blocks further requests until the host writes the count again. A mode input tells the address side whether each counted unit is one byte or one 16-bit word.

Top module: `dma_xfer_counter`

## Requirements
- R1: A host write to the count register (`host_sel`=0) places `host_wdata` in the base-count byte chosen by the byte pointer, and in the same clock edge copies the whole updated base count into the current count.
- R2: A count read (`host_sel`=0) returns, on `host_rdata` in the same cycle, the byte of the current count chosen by the pointer. It never returns the base count.
- R3: After the count is programmed to N, terminal count comes on the (N+1)-th accepted transfer strobe and on no earlier strobe.
- R4: Each accepted `xfer_done` strobe lowers the current count by exactly one when it is not zero.
- R5: When an accepted strobe finds the current count at 0000h, `tc` is high for the one cycle after that edge. With auto-initialize off, the current count becomes FFFFh.
- R6: With `autoinit_en`=1, an underflowing strobe reloads the current count from the base count, raises `tc`, and leaves `done` low.
- R7: The byte pointer has two states: 0 selects the low byte and 1 selects the high byte. Every count access, read or write, toggles it. `ptr_clr` forces it to 0 and takes priority over a toggle. Page accesses leave it alone.
- R8: A write with `host_sel`=1 loads the page value that drives `page_addr`. A page read returns it. Transfer strobes never change it.
- R9: An underflow with auto-initialize off sets `done`. While `done` is set, `grant` is low, `xfer_done` is ignored (no count change, no `tc`), and only a count write clears it.
- R10: `xfer_step` is 1 when `word_mode`=0 (the count is in bytes) and 2 when `word_mode`=1 (the count is in 16-bit words).
- R11: When a count write and a transfer strobe arrive in the same cycle, the write takes effect and the strobe is dropped.
- R12: After reset, both counts, the page, the pointer, `done` and `tc` are zero, and `grant` follows `dreq`.

Top module port list and default parameters: CNT_W=16, DATA_W=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (advances byte pointer on count reads) |
| host_sel | input | 1 | Register select: 0 count, 1 page |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| ptr_clr | input | 1 | Forces the byte pointer to the low byte |
| autoinit_en | input | 1 | Reload from base after terminal count |
| word_mode | input | 1 | 0: count in bytes, 1: count in words |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| dreq | input | 1 | Transfer request from the channel |
| grant | output | 1 | Request passed on while not done |
| tc | output | 1 | One-cycle terminal count pulse |
| done | output | 1 | Sticky terminal state without auto-initialize |
| page_addr | output | 8 | Address bits 23:16 |
| xfer_step | output | 2 | Bytes per counted transfer |

## Verification
If the current count is wrong by even one, `tc` comes one strobe early or late. A bench that counts strobes sees this on the first full run of any programmed value, and a count read shows it at once. A byte pointer that is out of step shows up on the next two-byte access as swapped or duplicated bytes. A stuck or missing `done` state shows the cycle after underflow, as `grant` still high or as a count that keeps moving past FFFFh. Sweeping many small counts, with and without reload, brings each of these errors out within a few dozen cycles of its cause.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_PAGE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr #(
  parameter int NLANES = 2,
  localparam int PTR_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access,
  input  logic             clr,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_nx;
  logic             ptr_en;

  always_comb begin
    ptr_en = clr | access;
    if (clr)                            ptr_nx = '0;
    else if (ptr_q == PTR_W'(NLANES-1)) ptr_nx = '0;
    else                                ptr_nx = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nx;
  end

  assign ptr = ptr_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !clr) |=> (ptr_q != $past(ptr_q))); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0)); // R7
endmodule

// File: rtl/dma_count_core.sv
module dma_count_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int NLANES = CNT_W / DATA_W,
  localparam int PTR_W  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              dec_req,
  input  logic              autoinit,
  output logic [CNT_W-1:0]  cur,
  output logic              tc,
  output logic              done
);
  logic [CNT_W-1:0] base_q, base_nx, cur_q, cur_nx;
  logic             tc_q, done_q, done_nx;
  logic             dec_fire, underflow, cur_en, done_en;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign base_nx[g*DATA_W +: DATA_W] =
      (wr_lane == PTR_W'(g)) ? wr_byte : base_q[g*DATA_W +: DATA_W];
  end

  always_comb begin
    dec_fire  = dec_req & ~wr_en & ~done_q;
    underflow = dec_fire & (cur_q == '0);
    cur_en    = wr_en | dec_fire;
    if (wr_en)          cur_nx = base_nx;
    else if (underflow) cur_nx = autoinit ? base_q : '1;
    else                cur_nx = cur_q - 1'b1;
    done_en = wr_en | (underflow & ~autoinit);
    done_nx = ~wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= base_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= underflow;
      if (done_en) done_q <= done_nx;
    end
  end

  assign cur  = cur_q;
  assign tc   = tc_q;
  assign done = done_q;

  AST_WRITE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cur_q == base_q)); // R1
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !wr_en && !done_q && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1)); // R4
  AST_TC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !wr_en && !done_q && cur_q == '0) |=> tc_q); // R5
  AST_NO_SPURIOUS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != '0 || wr_en || !dec_req) |=> !tc_q); // R3
  AST_AUTOINIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !wr_en && !done_q && cur_q == '0 && autoinit) |=> (cur_q == base_q && !done_q)); // R6
  AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_en) |=> ($stable(cur_q) && !tc_q)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec_req) |=> (cur_q == base_q && !tc_q)); // R11
endmodule

// File: rtl/dma_page_reg.sv
module dma_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_val,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= '0;
    else if (wr_en) page_q <= wr_val;
  end

  assign page = page_q;

  AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(page_q)); // R8
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ptr_clr,
  input  logic              autoinit_en,
  input  logic              word_mode,
  input  logic              xfer_done,
  input  logic              dreq,
  output logic              grant,
  output logic              tc,
  output logic              done,
  output logic [DATA_W-1:0] page_addr,
  output logic [1:0]        xfer_step
);
  import dma_cnt_pkg::*;

  localparam int NLANES = CNT_W / DATA_W;
  localparam int PTR_W  = (NLANES > 1) ? $clog2(NLANES) : 1;

  logic              sel_cnt, sel_page, cnt_acc, cnt_wr, page_wr;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  cur;
  logic [DATA_W-1:0] page_q;

  always_comb begin
    sel_cnt  = (host_sel == SEL_COUNT);
    sel_page = (host_sel == SEL_PAGE);
    cnt_acc  = (host_wr | host_rd) & sel_cnt;
    cnt_wr   = host_wr & sel_cnt;
    page_wr  = host_wr & sel_page;
  end

  dma_byte_ptr #(.NLANES(NLANES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .access (cnt_acc),
    .clr    (ptr_clr),
    .ptr    (ptr)
  );

  dma_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cnt_wr),
    .wr_lane  (ptr),
    .wr_byte  (host_wdata),
    .dec_req  (xfer_done),
    .autoinit (autoinit_en),
    .cur      (cur),
    .tc       (tc),
    .done     (done)
  );

  dma_page_reg #(.PAGE_W(DATA_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (page_wr),
    .wr_val (host_wdata),
    .page   (page_q)
  );

  always_comb begin
    host_rdata = sel_page ? page_q : cur[ptr*DATA_W +: DATA_W];
    grant      = dreq & ~done;
    page_addr  = page_q;
    xfer_step  = word_mode ? 2'd2 : 2'd1;
  end

  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !grant); // R9
  AST_STEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_step) && xfer_step != 2'd0); // R10
endmodule

// File: tb/dma_xfer_counter_bench.sv
`timescale 1ns/1ps
module dma_xfer_counter_bench;
  logic       clk, rst_n;
  logic       host_wr, host_rd, host_sel, ptr_clr, autoinit_en, word_mode;
  logic       xfer_done, dreq;
  logic [7:0] host_wdata, host_rdata, page_addr;
  logic       grant, tc, done;
  logic [1:0] xfer_step;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  dma_xfer_counter u_dma_xfer_counter (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ptr_clr(ptr_clr), .autoinit_en(autoinit_en), .word_mode(word_mode),
    .xfer_done(xfer_done), .dreq(dreq), .grant(grant), .tc(tc), .done(done),
    .page_addr(page_addr), .xfer_step(xfer_step)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic [7:0] d);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic sel, output logic [7:0] d);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_clr();
    ptr_clr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0;
  endtask

  task automatic prog16(input logic [15:0] v);
    do_clr();
    do_wr(1'b0, v[7:0]);
    do_wr(1'b0, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    do_clr();
    do_rd(1'b0, lo);
    do_rd(1'b0, hi);
    v = {hi, lo};
  endtask

  task automatic xfer(output logic t);
    xfer_done = 1'b1;
    @(negedge clk);
    t = tc;
    xfer_done = 1'b0;
  endtask

  task automatic run_count(input logic [15:0] n);
    logic t;
    logic [15:0] v;
    int first_tc, n_tc;
    first_tc = -1; n_tc = 0;
    autoinit_en = 1'b0;
    prog16(n);
    for (int i = 1; i <= int'(n) + 1; i++) begin
      xfer(t);
      if (t) begin n_tc++; if (first_tc < 0) first_tc = i; end
    end
    chk("R3 tc strobe index", first_tc, int'(n) + 1);
    chk("R5 single tc pulse", n_tc, 1);
    @(negedge clk);
    chk("R5 tc drops", tc, 0);
    rd16(v);
    chk("R5 wraps to FFFF", v, 16'hFFFF);
    chk("R9 done set", done, 1);
    dreq = 1'b1; #1;
    chk("R9 grant blocked", grant, 0);
    dreq = 1'b0;
    xfer(t);
    chk("R9 no tc while done", t, 0);
    rd16(v);
    chk("R9 count frozen", v, 16'hFFFF);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic        t;
    int          n_tc;
    host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0; ptr_clr = 0;
    autoinit_en = 0; word_mode = 0; xfer_done = 0; dreq = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 tc", tc, 0);
    chk("R12 done", done, 0);
    chk("R12 page", page_addr, 8'h00);
    dreq = 1'b1; #1;
    chk("R12 grant follows dreq", grant, 1);
    dreq = 1'b0;
    rd16(v);
    chk("R12 count", v, 16'h0000);

    // R1 write loads base and current
    prog16(16'h1234);
    rd16(v);
    chk("R1 write readback", v, 16'h1234);

    // R2 and R4: read shows current after decrements
    prog16(16'h000A);
    for (int i = 0; i < 3; i++) xfer(t);
    rd16(v);
    chk("R2 R4 current after 3", v, 16'h0007);
    xfer(t);
    rd16(v);
    chk("R4 one more", v, 16'h0006);
    prog16(16'h0100);
    xfer(t);
    rd16(v);
    chk("R4 borrow across bytes", v, 16'h00FF);

    // R3 R5 R9 sweep over small counts and byte borders
    for (int n = 0; n < 16; n++) run_count(16'(n));
    run_count(16'h00FF);
    run_count(16'h0100);

    // R9 count write clears done
    prog16(16'h0002);
    chk("R9 write clears done", done, 0);

    // R6 auto-initialize
    autoinit_en = 1'b1;
    prog16(16'h0003);
    for (int r = 0; r < 3; r++) begin
      n_tc = 0;
      for (int i = 1; i <= 4; i++) begin
        xfer(t);
        if (t) begin
          n_tc++;
          chk("R6 tc on fourth", i, 4);
        end
      end
      chk("R6 one tc per round", n_tc, 1);
      chk("R6 done stays low", done, 0);
      rd16(v);
      chk("R6 reloaded", v, 16'h0003);
    end
    prog16(16'h0000);
    for (int i = 0; i < 3; i++) begin
      xfer(t);
      chk("R6 zero base tc every strobe", t, 1);
    end
    autoinit_en = 1'b0;

    // R7 byte pointer toggling and clearing
    do_clr();
    do_wr(1'b0, 8'h34);
    do_wr(1'b0, 8'h12);
    do_rd(1'b0, b);
    chk("R7 wrap to low", b, 8'h34);
    do_rd(1'b0, b);
    chk("R7 read toggles", b, 8'h12);
    do_clr();
    do_wr(1'b0, 8'h77);
    do_clr();
    do_wr(1'b0, 8'h88);
    rd16(v);
    chk("R7 clear returns to low", v, 16'h1288);
    do_clr();
    do_rd(1'b0, b);
    do_wr(1'b0, 8'h99);
    rd16(v);
    chk("R7 read advances to high", v, 16'h9988);
    do_clr();
    do_wr(1'b1, 8'h5C);
    do_wr(1'b0, 8'h01);
    rd16(v);
    chk("R7 page access no toggle", v, 16'h9901);
    ptr_clr = 1'b1; host_sel = 1'b0; host_wdata = 8'h42; host_wr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0; host_wr = 1'b0;
    do_wr(1'b0, 8'h43);
    rd16(v);
    chk("R7 clear beats toggle", v, 16'h9943);

    // R8 page register
    do_wr(1'b1, 8'hA5);
    chk("R8 page written", page_addr, 8'hA5);
    prog16(16'h0004);
    for (int i = 0; i < 7; i++) xfer(t);
    chk("R8 page static", page_addr, 8'hA5);
    do_rd(1'b1, b);
    chk("R8 page read", b, 8'hA5);

    // R11 write beats strobe
    prog16(16'h0010);
    do_clr();
    host_sel = 1'b0; host_wdata = 8'h22; host_wr = 1'b1; xfer_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; xfer_done = 1'b0;
    rd16(v);
    chk("R11 write wins", v, 16'h0022);
    prog16(16'h0000);
    do_clr();
    host_sel = 1'b0; host_wdata = 8'h00; host_wr = 1'b1; xfer_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; xfer_done = 1'b0;
    chk("R11 no tc when write wins", tc, 0);

    // R10 step size
    word_mode = 1'b0; #1;
    chk("R10 byte step", xfer_step, 2'd1);
    word_mode = 1'b1; #1;
    chk("R10 word step", xfer_step, 2'd2);
    word_mode = 1'b0;

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule